// File: doc/BRIEF.md
# Microsequencer Address Parity Checker

This block holds the microprogram address register and picks the next microword address on every cycle. The address comes from one of three places: an opcode dispatch address, a saved subroutine return address, or the next-address field of the word just fetched. For a conditional step, the selected status bit is merged into bit 0 of that field. The external store is addressed by `mar` and returns that word's fields on the same cycle.

Each address carries an even-parity bit. Every word holds two parity bits. One covers the next address that the word supplies. The other covers the word's own location and is matched against the address register's parity bit, so the location check needs no parity tree on the address path. There are two separate copies of the branch-condition select. One copy sets address bit 0. The other flips the parity bit. A fault in either copy therefore shows up as a location-parity mismatch on the next fetch.

The return register does two jobs. After a call it holds the return point. When no return is pending, it follows the address register through its own load path and is compared with it on every cycle. All detected faults set a sticky error flag.

Top module: `mseq_parity`

## Requirements
- R1: While `rst_n` is low, and just after it rises, `mar` is 0 and `err` is 0. A later reset clears a set `err`.
- R2: `dispatch` high loads `mar` from `start_addr` and the parity bit from `start_par` at the next edge. Dispatch has priority over `do_ret`, `do_call` and any branch condition. A wrong `start_par` is reported by the location check on the next fetch.
- R3: With no dispatch, no return and no taken branch, `mar` loads `nxt_addr` at the next edge. `cond_sel` values 0, 6 and 7 never branch.
- R4: `cond_sel` = k, for k from 1 to 5, selects `status[k-1]`. When that bit is 1, `mar` bit 0 is set and the parity bit is the complement of `pf`. Bit 0 of `nxt_addr` is 0 in a conditional word.
- R5: On a fetch, if `pn` differs from the even parity of the current `mar` (the XOR of its bits), `err` is 1 after the next edge.
- R6: Once set, `err` stays 1 until reset.
- R7: The first fetch after reset never sets `err`, even with a wrong `pn`.
- R8: `do_call` (without dispatch or return) jumps to the next-address path as in R3 and R4. It saves `mar`+1 as the return address and suspends the shadow compare.
- R9: `do_ret` (without dispatch) loads `mar` with the saved return address and its correct parity, then resumes the shadow compare.
- R10: While no return is pending, the return register loads the same next address as `mar`. Any difference between the two sets `err`. A correct sequence of steps, branches, calls and returns never sets `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dispatch | input | 1 | Load the opcode start address |
| start_addr | input | 9 | Opcode start address |
| start_par | input | 1 | Even parity supplied with `start_addr` |
| nxt_addr | input | 9 | Next-address field of the fetched word |
| pf | input | 1 | Fetched word: parity of `nxt_addr` |
| pn | input | 1 | Fetched word: parity of its own location |
| cond_sel | input | 3 | Branch condition select, 0 = none |
| status | input | 5 | Status bits for conditional branches |
| do_call | input | 1 | Fetched word is a subroutine call |
| do_ret | input | 1 | Fetched word is a subroutine return |
| mar | output | 9 | Microprogram address register |
| err | output | 1 | Sticky fault flag |

## Verification
Both results are registered. The new `mar` value and any `err` caused by a fetch appear one rising edge after the fetch's inputs are presented. The bench sets each fetch's inputs on a falling edge, then waits one rising edge and reads both outputs on the following falling edge. It derives `pn` for each fetch from its own running copy of the expected address. A missing parity flip on a branch, a wrong return parity, or a diverging shadow therefore shows up as an unexpected `err` on the very next sample.

// File: rtl/mseq_parity.sv
module mseq_parity #(
  parameter int AW    = 9,
  parameter int NSTAT = 5,
  parameter int SELW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dispatch,
  input  logic [AW-1:0]    start_addr,
  input  logic             start_par,
  input  logic [AW-1:0]    nxt_addr,
  input  logic             pf,
  input  logic             pn,
  input  logic [SELW-1:0]  cond_sel,
  input  logic [NSTAT-1:0] status,
  input  logic             do_call,
  input  logic             do_ret,
  output logic [AW-1:0]    mar,
  output logic             err
);

  logic [AW-1:0] mar_q, rar_q;
  logic          mar_par_q, ret_par_q, busy_q, fresh_q, err_q;

  logic br_a;
  always_comb begin
    br_a = 1'b0;
    for (int i = 0; i < NSTAT; i++)
      if (cond_sel == SELW'(i + 1)) br_a = status[i];
  end

  logic [NSTAT-1:0] br_shift;
  assign br_shift = status >> (cond_sel - SELW'(1));
  wire br_b = br_shift[0];

  wire [AW-1:0] seq_addr = {nxt_addr[AW-1:1], nxt_addr[0] | br_a};
  wire [AW-1:0] shd_addr = {nxt_addr[AW-1:1], nxt_addr[0] | br_a};
  wire [AW-1:0] ret_addr = mar_q + AW'(1);

  wire pn_bad  = pn != mar_par_q;
  wire shd_bad = !busy_q && (rar_q != mar_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q     <= '0;
      mar_par_q <= 1'b0;
      rar_q     <= '0;
      ret_par_q <= 1'b0;
      busy_q    <= 1'b0;
      fresh_q   <= 1'b1;
      err_q     <= 1'b0;
    end else begin
      fresh_q <= 1'b0;
      err_q   <= err_q | (!fresh_q & (pn_bad | shd_bad));
      if (dispatch) begin
        mar_q     <= start_addr;
        mar_par_q <= start_par;
        rar_q     <= start_addr;
        busy_q    <= 1'b0;
      end else if (do_ret) begin
        mar_q     <= rar_q;
        mar_par_q <= ret_par_q;
        busy_q    <= 1'b0;
      end else begin
        mar_q     <= seq_addr;
        mar_par_q <= pf ^ br_b;
        if (do_call) begin
          rar_q     <= ret_addr;
          ret_par_q <= ^ret_addr;
          busy_q    <= 1'b1;
        end else if (!busy_q) begin
          rar_q <= shd_addr;
        end
      end
    end
  end

  assign mar = mar_q;
  assign err = err_q;

endmodule

module mseq_parity_chk #(
  parameter int AW    = 9,
  parameter int NSTAT = 5,
  parameter int SELW  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dispatch,
  input logic [AW-1:0]    start_addr,
  input logic [AW-1:0]    nxt_addr,
  input logic             pf,
  input logic             pn,
  input logic [SELW-1:0]  cond_sel,
  input logic [NSTAT-1:0] status,
  input logic             do_ret,
  input logic [AW-1:0]    mar,
  input logic             mar_par,
  input logic             err
);

  logic fresh;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fresh <= 1'b1;
    else        fresh <= 1'b0;

  logic hit;
  always_comb begin
    hit = 1'b0;
    for (int k = 1; k <= NSTAT; k++)
      if (int'(cond_sel) == k) hit = status[k-1];
  end

  wire plain = !dispatch && !do_ret;

  AST_DISP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |=> mar == $past(start_addr)); // R2
  AST_SEQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (plain && !hit) |=> mar == $past(nxt_addr)); // R3
  AST_BR_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (plain && hit) |=> mar[0]); // R4
  AST_BR_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    plain |=> mar_par == ($past(pf) ^ $past(hit))); // R4
  AST_PN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!fresh && (pn != mar_par)) |=> err); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R6
  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |=> !err); // R7

endmodule

bind mseq_parity mseq_parity_chk #(.AW(AW), .NSTAT(NSTAT), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dispatch(dispatch), .start_addr(start_addr),
  .nxt_addr(nxt_addr), .pf(pf), .pn(pn), .cond_sel(cond_sel), .status(status),
  .do_ret(do_ret), .mar(mar_q), .mar_par(mar_par_q), .err(err_q)
);

// File: tb/sim_mseq_parity.sv
`timescale 1ns/1ps
module sim_mseq_parity;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dispatch, start_par, pf, pn, do_call, do_ret;
  logic [8:0] start_addr, nxt_addr, mar;
  logic [2:0] cond_sel;
  logic [4:0] status;
  logic       err;

  always #2.5 clk = ~clk;

  mseq_parity u0 (
    .clk(clk), .rst_n(rst_n), .dispatch(dispatch), .start_addr(start_addr),
    .start_par(start_par), .nxt_addr(nxt_addr), .pf(pf), .pn(pn),
    .cond_sel(cond_sel), .status(status), .do_call(do_call), .do_ret(do_ret),
    .mar(mar), .err(err)
  );

  int total = 0, bad = 0;
  logic [8:0] cur;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit d, input logic [8:0] st, input bit spflip,
                      input logic [8:0] nx, input logic [2:0] cs, input logic [4:0] sb,
                      input bit ca, input bit rt, input bit pnflip);
    dispatch = d; start_addr = st; start_par = (^st) ^ spflip;
    nxt_addr = nx; pf = ^nx; cond_sel = cs; status = sb;
    do_call = ca; do_ret = rt; pn = (^cur) ^ pnflip;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(0, 9'h0, 0, 9'h0, 3'd0, 5'd0, 0, 0, 0);
    chk(mar == 9'h0 && err == 1'b0, "R1 in reset", {mar, err}, 0);
    rst_n = 1'b1;
    cur = 9'h0;
    chk(mar == 9'h0 && err == 1'b0, "R1 after release", {mar, err}, 0);
  endtask

  // {req, dispatch, start, nxt, cond, status, call, ret, expected mar}
  localparam int NV = 12;
  localparam logic [41:0] VEC [NV] = '{
    {4'd3,  1'b0, 9'h000, 9'h010, 3'd0, 5'b00000, 1'b0, 1'b0, 9'h010}, // R3
    {4'd3,  1'b0, 9'h000, 9'h155, 3'd0, 5'b00000, 1'b0, 1'b0, 9'h155}, // R3
    {4'd2,  1'b1, 9'h0A3, 9'h077, 3'd0, 5'b00000, 1'b0, 1'b0, 9'h0A3}, // R2
    {4'd4,  1'b0, 9'h000, 9'h040, 3'd2, 5'b00010, 1'b0, 1'b0, 9'h041}, // R4 taken
    {4'd4,  1'b0, 9'h000, 9'h082, 3'd5, 5'b01111, 1'b0, 1'b0, 9'h082}, // R4 not taken
    {4'd4,  1'b0, 9'h000, 9'h1F0, 3'd1, 5'b00001, 1'b0, 1'b0, 9'h1F1}, // R4 taken
    {4'd3,  1'b0, 9'h000, 9'h0C8, 3'd7, 5'b11111, 1'b0, 1'b0, 9'h0C8}, // R3 select 7
    {4'd8,  1'b0, 9'h000, 9'h100, 3'd0, 5'b00000, 1'b1, 1'b0, 9'h100}, // R8 call
    {4'd8,  1'b0, 9'h000, 9'h101, 3'd6, 5'b11111, 1'b0, 1'b0, 9'h101}, // R8 busy
    {4'd9,  1'b0, 9'h000, 9'h033, 3'd0, 5'b00000, 1'b0, 1'b1, 9'h0C9}, // R9 return
    {4'd10, 1'b0, 9'h000, 9'h0CA, 3'd0, 5'b00000, 1'b0, 1'b0, 9'h0CA}, // R10 resumed
    {4'd4,  1'b0, 9'h000, 9'h1FE, 3'd4, 5'b01000, 1'b0, 1'b0, 9'h1FF}  // R4 taken
  };

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cur = 9'h0;
    @(negedge clk);
    do_reset();

    // R7: wrong pn on the first fetch is ignored
    step(0, 9'h0, 0, 9'h000, 3'd0, 5'd0, 0, 0, 1);
    chk(err == 1'b0, "R7 first fetch", err, 0);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      step(v[37], v[36:28], 0, v[27:19], v[18:16], v[15:11], v[10], v[9], 0);
      chk(mar == v[8:0], $sformatf("R%0d vector %0d mar", v[41:38], i), mar, v[8:0]);
      chk(err == 1'b0, $sformatf("R10 vector %0d err", i), err, 0);
      cur = v[8:0];
    end

    // R2: dispatch wins over return, call and branch
    step(1, 9'h1A0, 0, 9'h0F0, 3'd1, 5'b00001, 1, 1, 0);
    chk(mar == 9'h1A0, "R2 priority", mar, 9'h1A0);
    cur = 9'h1A0;

    // R5: wrong location parity
    step(0, 9'h0, 0, 9'h002, 3'd0, 5'd0, 0, 0, 1);
    chk(err == 1'b1, "R5 pn mismatch", err, 1);
    cur = 9'h002;

    // R6: sticky through good fetches
    step(0, 9'h0, 0, 9'h004, 3'd0, 5'd0, 0, 0, 0);
    cur = 9'h004;
    chk(err == 1'b1, "R6 sticky 1", err, 1);
    step(1, 9'h011, 0, 9'h000, 3'd0, 5'd0, 0, 0, 0);
    cur = 9'h011;
    chk(err == 1'b1, "R6 sticky 2", err, 1);

    do_reset();

    // R2: wrong supplied start parity is caught on the next fetch
    step(1, 9'h003, 1, 9'h000, 3'd0, 5'd0, 0, 0, 0);
    chk(mar == 9'h003 && err == 1'b0, "R2 bad start parity load", {mar, err}, {9'h003, 1'b0});
    cur = 9'h003;
    step(0, 9'h0, 0, 9'h008, 3'd0, 5'd0, 0, 0, 0);
    chk(err == 1'b1, "R2 bad start parity detect", err, 1);

    finish_run();
  end

endmodule